// File: doc/BRIEF.md
# Reuse-Driven Placement Mode Governor

This block is one global arbiter for a whole last-level cache. It decides whether lines that are touched get copied into the cheap-to-reach way group ("placement mode"), or whether the cache behaves as an ordinary set-associative array ("conventional mode"). It decides by watching how often recently placed data is reused. A single signed, saturating score rises by two on each reuse event that counts and falls by one on each event that does not.

Each valid access arrives as one strobe with two flags: whether it hit the low-energy way and whether it hit the most-recently-used way of its set. The flag that counts depends on the current mode. In placement mode only the low-energy-way flag counts. In conventional mode only the MRU-way flag counts. The mode follows the sign of the updated score. A negative score selects conventional mode, a positive score selects placement mode, and a score of zero leaves the mode where it is. The score and a wrapping count of mode changes are also driven out so they can be observed.

The mode is held by a two-state machine. The states are `MODE_PLACE` (placement enabled, the reset state) and `MODE_CONV` (conventional). There are two transitions. `GO_CONV` leaves `MODE_PLACE` on a valid access whose updated score is below zero. `GO_PLACE` leaves `MODE_CONV` on a valid access whose updated score is above zero. Every other case stays in the current state.

Top module: `reuse_mode_governor`

## Requirements
- R1: While reset (`rst_n` low) is applied, `score` is 0, `place_en` is 1 (state `MODE_PLACE`) and `mode_flips` is 0.
- R2: `score` is a 5-bit two's-complement value and always lies between -15 and +15 inclusive.
- R3: A valid access whose counted flag is 1 adds 2 to `score`, saturating at +15, so 14 becomes 15 and 15 stays 15.
- R4: A valid access whose counted flag is 0 subtracts 1 from `score`, saturating at -15, so -15 stays -15.
- R5: While `place_en` is 1, the counted flag is `lp_hit`, and `mru_hit` has no effect on `score` or the mode.
- R6: While `place_en` is 0, the counted flag is `mru_hit`, and `lp_hit` has no effect on `score` or the mode.
- R7: After a valid access, the mode is set from the updated score. Below 0 gives `place_en` = 0 (`GO_CONV`), above 0 gives `place_en` = 1 (`GO_PLACE`), and exactly 0 keeps the previous mode.
- R8: A cycle with `acc_valid` low leaves `score`, `place_en` and `mode_flips` unchanged, whatever the hit flags are.
- R9: Inputs are sampled on a rising clock edge, and every output reflects that access just after that same edge and not before it.
- R10: `mode_flips` increases by one, wrapping modulo 2^FLIP_W, on every change of `place_en`, and is otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_valid | input | 1 | A cache access is presented this cycle |
| lp_hit | input | 1 | The access hit in the low-energy way group |
| mru_hit | input | 1 | The access hit in the MRU way of its set |
| place_en | output | 1 | 1 = copy-on-touch placement enabled, 0 = conventional mode |
| score | output | CNT_W (5) | Signed reuse score, two's complement |
| mode_flips | output | FLIP_W (16) | Wrapping count of mode changes |

## Verification
Every result is due exactly one clock edge after the access is sampled. The score, the mode and the flip count are all registered on that same edge, and the mode is decided from the score being written in that cycle, so it never lags one access behind. The bench applies each access at a falling edge. It probes the outputs once before the next rising edge, where they must still hold their old values, and once at the falling edge after it, where they must already hold the value the arithmetic model predicts. Sweeps cover every combination of the three inputs from many score values and in both modes. They also drive the score into both saturation limits and push the flip count through its wrap using a narrow width.

// File: rtl/reuse_mon_pkg.sv
package reuse_mon_pkg;

    // Operating mode of the governor.
    typedef enum logic {
        MODE_PLACE = 1'b0,
        MODE_CONV  = 1'b1
    } reuse_mode_e;

endpackage

// File: rtl/reuse_event_pick.sv
module reuse_event_pick
    import reuse_mon_pkg::*;
(
    input  reuse_mode_e mode,
    input  logic        lp_hit,
    input  logic        mru_hit,
    output logic        scored_hit
);

    // The mode decides which hit flag is scored.
    always_comb begin
        unique case (mode)
            MODE_PLACE: scored_hit = lp_hit;
            MODE_CONV:  scored_hit = mru_hit;
            default:    scored_hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/reuse_sat_counter.sv
module reuse_sat_counter #(
    parameter int CNT_W     = 5,
    parameter int CNT_LIM   = 15,
    parameter int UP_STEP   = 2,
    parameter int DOWN_STEP = 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic                    scored_hit,
    output logic signed [CNT_W-1:0] cnt_q,
    output logic signed [CNT_W-1:0] cnt_d
);

    // Two guard bits so that a step past either limit cannot wrap.
    localparam int EW = CNT_W + 2;
    localparam logic signed [EW-1:0] HI_W   = EW'(CNT_LIM);
    localparam logic signed [EW-1:0] LO_W   = EW'(-CNT_LIM);
    localparam logic signed [EW-1:0] UP_W   = EW'(UP_STEP);
    localparam logic signed [EW-1:0] DOWN_W = EW'(DOWN_STEP);

    logic signed [EW-1:0] wide_cur;
    logic signed [EW-1:0] wide_up;
    logic signed [EW-1:0] wide_down;
    logic signed [EW-1:0] wide_sel;

    always_comb begin
        wide_cur  = {{2{cnt_q[CNT_W-1]}}, cnt_q};
        wide_up   = wide_cur + UP_W;
        wide_down = wide_cur - DOWN_W;
        if (!upd) begin
            wide_sel = wide_cur;
        end else if (scored_hit) begin
            wide_sel = (wide_up > HI_W) ? HI_W : wide_up;
        end else begin
            wide_sel = (wide_down < LO_W) ? LO_W : wide_down;
        end
        cnt_d = wide_sel[CNT_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/reuse_mode_fsm.sv
module reuse_mode_fsm
    import reuse_mon_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    upd,
    input  logic signed [CNT_W-1:0] cnt_d,
    output reuse_mode_e             mode_q,
    output logic                    place_en,
    output logic                    flip
);

    reuse_mode_e mode_d;
    logic        go_conv;
    logic        go_place;

    // Transition conditions: strict comparisons against zero.
    always_comb begin
        go_conv  = upd && (cnt_d < 0);
        go_place = upd && (cnt_d > 0);
        mode_d   = mode_q;
        unique case (mode_q)
            MODE_PLACE: if (go_conv)  mode_d = MODE_CONV;
            MODE_CONV:  if (go_place) mode_d = MODE_PLACE;
            default:    mode_d = MODE_PLACE;
        endcase
        flip = (mode_d != mode_q);
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_PLACE;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Outputs from state.
    always_comb begin
        unique case (mode_q)
            MODE_PLACE: place_en = 1'b1;
            MODE_CONV:  place_en = 1'b0;
            default:    place_en = 1'b1;
        endcase
    end

endmodule

// File: rtl/reuse_flip_tally.sv
module reuse_flip_tally #(
    parameter int FLIP_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flip,
    output logic [FLIP_W-1:0] flips
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flips <= '0;
        end else if (flip) begin
            flips <= flips + 1'b1;
        end
    end

endmodule

// File: rtl/reuse_mode_governor.sv
module reuse_mode_governor
    import reuse_mon_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int CNT_LIM   = 15,
    parameter int HIT_STEP  = 2,
    parameter int MISS_STEP = 1,
    parameter int FLIP_W    = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    acc_valid,
    input  logic                    lp_hit,
    input  logic                    mru_hit,
    output logic                    place_en,
    output logic signed [CNT_W-1:0] score,
    output logic [FLIP_W-1:0]       mode_flips
);

    reuse_mode_e             mode_q;
    logic                    scored_hit;
    logic signed [CNT_W-1:0] cnt_d;
    logic                    flip;

    reuse_event_pick u_pick (
        .mode       (mode_q),
        .lp_hit     (lp_hit),
        .mru_hit    (mru_hit),
        .scored_hit (scored_hit)
    );

    reuse_sat_counter #(
        .CNT_W     (CNT_W),
        .CNT_LIM   (CNT_LIM),
        .UP_STEP   (HIT_STEP),
        .DOWN_STEP (MISS_STEP)
    ) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (acc_valid),
        .scored_hit (scored_hit),
        .cnt_q      (score),
        .cnt_d      (cnt_d)
    );

    reuse_mode_fsm #(
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (acc_valid),
        .cnt_d    (cnt_d),
        .mode_q   (mode_q),
        .place_en (place_en),
        .flip     (flip)
    );

    reuse_flip_tally #(
        .FLIP_W (FLIP_W)
    ) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .flip  (flip),
        .flips (mode_flips)
    );

endmodule

// File: rtl/reuse_mode_governor_chk.sv
module reuse_mode_governor_chk #(
    parameter int CNT_W     = 5,
    parameter int CNT_LIM   = 15,
    parameter int HIT_STEP  = 2,
    parameter int MISS_STEP = 1,
    parameter int FLIP_W    = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    acc_valid,
    input logic                    lp_hit,
    input logic                    mru_hit,
    input logic                    place_en,
    input logic signed [CNT_W-1:0] score,
    input logic [FLIP_W-1:0]       mode_flips
);

    logic counted;
    assign counted = place_en ? lp_hit : mru_hit;

    AST_SCORE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(score) >= -CNT_LIM) && (int'(score) <= CNT_LIM)); // R2

    AST_HIT_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && counted) |=>
            ((int'(score) == CNT_LIM) || (int'(score) - int'($past(score)) == HIT_STEP))); // R3

    AST_MISS_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !counted) |=>
            ((int'(score) == -CNT_LIM) || (int'($past(score)) - int'(score) == MISS_STEP))); // R4

    AST_NEG_CONV: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(score) < 0) |-> !place_en); // R7

    AST_POS_PLACE: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(score) > 0) |-> place_en); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> ($stable(score) && $stable(place_en) && $stable(mode_flips))); // R8

    AST_FLIP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (place_en != $past(place_en)) |-> (mode_flips == $past(mode_flips) + 1'b1)); // R10

    AST_FLIP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (place_en == $past(place_en)) |-> $stable(mode_flips)); // R10

endmodule

bind reuse_mode_governor reuse_mode_governor_chk #(
    .CNT_W     (CNT_W),
    .CNT_LIM   (CNT_LIM),
    .HIT_STEP  (HIT_STEP),
    .MISS_STEP (MISS_STEP),
    .FLIP_W    (FLIP_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_valid  (acc_valid),
    .lp_hit     (lp_hit),
    .mru_hit    (mru_hit),
    .place_en   (place_en),
    .score      (score),
    .mode_flips (mode_flips)
);

// File: tb/reuse_mode_governor_test.sv
`timescale 1ns/1ps
module reuse_mode_governor_test;

    localparam int CW  = 5;
    localparam int LIM = 15;
    localparam int FW  = 3;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 acc_valid = 1'b0;
    logic                 lp_hit = 1'b0;
    logic                 mru_hit = 1'b0;
    logic                 place_en;
    logic signed [CW-1:0] score;
    logic [FW-1:0]        mode_flips;

    int checks = 0;
    int errors = 0;
    int ref_cnt = 0;
    int ref_place = 1;
    int ref_flips = 0;

    always #4 clk = ~clk;

    reuse_mode_governor #(.FLIP_W(FW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_valid  (acc_valid),
        .lp_hit     (lp_hit),
        .mru_hit    (mru_hit),
        .place_en   (place_en),
        .score      (score),
        .mode_flips (mode_flips)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One access: apply at a falling edge, probe before the rising edge,
    // compare against the model at the following falling edge.
    task automatic step(input bit v, input bit lp, input bit mru);
        string tag;
        int    sc;
        int    alt;
        int    old_cnt;
        int    old_place;
        acc_valid = v;
        lp_hit    = lp;
        mru_hit   = mru;
        #2;
        check("R9", "score before edge", int'(score), ref_cnt);
        @(posedge clk);
        old_cnt   = ref_cnt;
        old_place = ref_place;
        sc  = ref_place ? int'(lp) : int'(mru);
        alt = ref_place ? int'(mru) : int'(lp);
        if (v) begin
            if (sc != 0) ref_cnt = (ref_cnt + 2 > LIM) ? LIM : ref_cnt + 2;
            else         ref_cnt = (ref_cnt - 1 < -LIM) ? -LIM : ref_cnt - 1;
            if (ref_cnt < 0)      ref_place = 0;
            else if (ref_cnt > 0) ref_place = 1;
            if (ref_place != old_place) ref_flips = (ref_flips + 1) % (1 << FW);
        end
        if (!v)                                    tag = "R8";
        else if (ref_place != old_place)           tag = "R7";
        else if (sc != 0 && old_cnt + 2 > LIM)     tag = "R3";
        else if (sc == 0 && old_cnt - 1 < -LIM)    tag = "R4";
        else if (alt != sc)                        tag = old_place ? "R5" : "R6";
        else                                       tag = (sc != 0) ? "R3" : "R4";
        @(negedge clk);
        check(tag, "score", int'(score), ref_cnt);
        check(tag, "place_en", int'(place_en), ref_place);
        check("R10", "mode_flips", int'(mode_flips), ref_flips);
        check("R2", "score in range",
              ((int'(score) >= -LIM) && (int'(score) <= LIM)) ? 1 : 0, 1);
    endtask

    initial begin
        #100000;
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "score in reset", int'(score), 0);
        check("R1", "place_en in reset", int'(place_en), 1);
        check("R1", "mode_flips in reset", int'(mode_flips), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Placement-mode hits, then mru_hit alone must count as a miss (R5).
        repeat (3) step(1, 1, 0);
        repeat (2) step(1, 0, 1);
        // Drive down to the lower limit (R4, R7).
        repeat (25) step(1, 0, 0);
        // Conventional mode: lp_hit alone is a miss (R6).
        repeat (3) step(1, 1, 0);
        // MRU hits climb back out to placement mode.
        repeat (12) step(1, 0, 1);
        // Idle cycles with every flag combination (R8).
        for (int c = 0; c < 4; c++) step(0, c[1], c[0]);
        // Top saturation, then 14 + 2 = 15 (R3).
        repeat (10) step(1, 1, 1);
        step(1, 0, 0);
        step(1, 1, 1);
        // Exhaustive input combinations from many score values and both modes.
        for (int r = 0; r < 24; r++) begin
            for (int c = 0; c < 8; c++) step(c[2], c[1], c[0]);
        end
        // Oscillating pattern to drive many mode changes and wrap the tally.
        for (int n = 0; n < 200; n++) begin
            step((n % 5) != 0, ((n / 3) % 2) == 1, ((n * 7) % 4) < 2);
        end
        finish_run();
    end

endmodule